// File: doc/BRIEF.md
# Write-Path Protocol Monitor

This block sits beside one write interface of a memory-mapped bus and watches the address, data and response channels without ever driving them. Every accepted address beat is logged with its transaction ID and burst length in a small table of outstanding writes. Data beats are counted against the oldest address that still awaits data, and the position of the final-beat marker is compared with the length from the address phase. Each response is paired by ID with a write whose data has completed.

Each rule it enforces has its own error bit. A bit stays set until a clear pulse arrives, so a long regression can be examined after it ends. A separate status bit records responses that report a failure code, because a failed write is legal traffic and not a protocol fault. A counter counts writes whose response has been accepted. The monitor places no limit on the delay before a response.

Top module: `axi_wr_checker`

## Requirements
- R1: A beat on any channel is taken only in a cycle where both its valid and its ready input are high. Cycles with valid high and ready low are not counted as beats.
- R2: A data beat that carries the last marker before the beat count reaches the address length plus one sets error bit 0 (early last). That beat also ends the burst.
- R3: A data beat that reaches the count of address length plus one without the last marker sets error bit 1 (missing last). That beat also ends the burst.
- R4: If the data channel was stalled (valid high, ready low) in the previous cycle, and in this cycle valid has dropped or the data or strobes differ, error bit 2 is set.
- R5: The same stall rule covers the address channel (ID and length) and sets bit 3. It covers the response channel (ID and response code) and sets bit 4.
- R6: An accepted response sets error bit 5 when no outstanding write with the same ID has finished its data. This covers a second response to one burst and a response that arrives before the last beat.
- R7: An address accepted while 4 writes are outstanding sets error bit 6 and is not logged.
- R8: A data beat accepted when no logged write awaits data sets error bit 7.
- R9: Any number of idle cycles between the last data beat and the response raises no error bit.
- R10: An accepted response with a code other than 0 (OKAY) sets the sticky `resp_fail` output and leaves the error bits unchanged.
- R11: `done_count` rises by one in the cycle after a response that pairs with an outstanding write is accepted. It does not rise when a last data beat is accepted.
- R12: Error bits and `resp_fail` stay set until `clr_err` is high at a clock edge. An event in that same cycle still sets its bit. A synchronous low `rst_n` zeroes all outputs.
- R13: Responses may return in any order across IDs. Each one retires the oldest completed write that carries its ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_err | input | 1 | Clears the sticky error and status bits |
| aw_valid | input | 1 | Address channel valid |
| aw_ready | input | 1 | Address channel ready |
| aw_id | input | ID_W | Write transaction ID |
| aw_len | input | LEN_W | Burst length minus one |
| w_valid | input | 1 | Data channel valid |
| w_ready | input | 1 | Data channel ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Byte strobes |
| w_last | input | 1 | Final-beat marker |
| b_valid | input | 1 | Response channel valid |
| b_ready | input | 1 | Response channel ready |
| b_id | input | ID_W | Response ID |
| b_resp | input | 2 | Response code |
| err_flags | output | 8 | Sticky per-rule error bits |
| resp_fail | output | 1 | Sticky flag for a non-OKAY response |
| done_count | output | DONE_W | Count of completed writes |

## Verification
Seeded random legal traffic runs first. It uses random lengths, IDs and stall lengths on all three channels, and varies the delay before the response. Some rounds keep two writes outstanding with their responses swapped. This traffic must leave every error bit clear and the completion count exact, which separates real stalls from miscounted beats. Directed cases then break one rule each: an early or missing last marker, payload changed during a stall, duplicate or premature or unknown responses, a fifth outstanding address, and data with no address. Each case must raise only its own bit. Further directed cases cover a very long response delay, a failure code, and clear timing.

// File: rtl/axi_wrchk_pkg.sv
package axi_wrchk_pkg;

    localparam int NUM_ERR = 8;

    // bit positions inside err_flags
    typedef enum int unsigned {
        E_LAST_EARLY   = 0,
        E_LAST_MISSING = 1,
        E_W_UNSTABLE   = 2,
        E_AW_UNSTABLE  = 3,
        E_B_UNSTABLE   = 4,
        E_B_ORPHAN     = 5,
        E_Q_OVERFLOW   = 6,
        E_W_NO_ADDR    = 7
    } err_idx_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axi_wrchk_stall.sv
module axi_wrchk_stall #(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             ready,
    input  logic [PAY_W-1:0] payload,
    output logic             viol
);

    typedef struct packed {
        logic             held;
        logic [PAY_W-1:0] pay;
    } st_t;

    st_t q, d;

    always_comb begin
        d      = q;
        d.held = valid && !ready;
        d.pay  = payload;
        viol   = q.held && (!valid || (payload != q.pay));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/axi_wrchk_queue.sv
module axi_wrchk_queue #(
    parameter int ID_W  = 4,
    parameter int LEN_W = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aw_fire,
    input  logic [ID_W-1:0]  aw_id,
    input  logic [LEN_W-1:0] aw_len,
    input  logic             w_fire,
    input  logic             w_last,
    input  logic             b_fire,
    input  logic [ID_W-1:0]  b_id,
    output logic             b_match,
    output logic             err_orphan,
    output logic             err_overflow,
    output logic             err_no_addr,
    output logic             err_early,
    output logic             err_missing
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [LEN_W-1:0] len;
        logic             done;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic [CNT_W-1:0]  cnt;
        logic [LEN_W-1:0]  beat;
    } q_t;

    q_t q, d;
    logic pend_found;

    always_comb begin
        int  hit_idx;
        int  pend_idx;
        logic hit;
        logic final_beat;

        d            = q;
        b_match      = 1'b0;
        err_orphan   = 1'b0;
        err_overflow = 1'b0;
        err_no_addr  = 1'b0;
        err_early    = 1'b0;
        err_missing  = 1'b0;
        hit          = 1'b0;
        hit_idx      = 0;
        pend_found   = 1'b0;
        pend_idx     = 0;
        final_beat   = 1'b0;

        // response retires the oldest completed entry with the same ID
        for (int i = 0; i < DEPTH; i++) begin
            if (!hit && (i < int'(d.cnt)) && d.slot[i].done && (d.slot[i].id == b_id)) begin
                hit     = 1'b1;
                hit_idx = i;
            end
        end
        if (b_fire) begin
            if (hit) begin
                b_match = 1'b1;
                for (int i = 0; i < DEPTH - 1; i++) begin
                    if (i >= hit_idx) d.slot[i] = d.slot[i+1];
                end
                d.slot[DEPTH-1] = '0;
                d.cnt           = d.cnt - 1'b1;
            end else begin
                err_orphan = 1'b1;
            end
        end

        // new address is appended behind the existing entries
        if (aw_fire) begin
            if (int'(d.cnt) >= DEPTH) begin
                err_overflow = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (i == int'(d.cnt)) begin
                        d.slot[i].id   = aw_id;
                        d.slot[i].len  = aw_len;
                        d.slot[i].done = 1'b0;
                    end
                end
                d.cnt = d.cnt + 1'b1;
            end
        end

        // data beats belong to the oldest entry still waiting for data
        for (int i = 0; i < DEPTH; i++) begin
            if (!pend_found && (i < int'(d.cnt)) && !d.slot[i].done) begin
                pend_found = 1'b1;
                pend_idx   = i;
            end
        end
        if (w_fire) begin
            if (!pend_found) begin
                err_no_addr = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (i == pend_idx) final_beat = (d.beat == d.slot[i].len);
                end
                err_early   = w_last && !final_beat;
                err_missing = !w_last && final_beat;
                if (w_last || final_beat) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (i == pend_idx) d.slot[i].done = 1'b1;
                    end
                    d.beat = '0;
                end else begin
                    d.beat = d.beat + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.cnt) <= DEPTH);

    // R2
    beat_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_fire && w_last && pend_found) |=> (q.beat == '0));

    // R6
    orphan_keeps_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_orphan && !aw_fire) |=> (q.cnt == $past(q.cnt)));

endmodule

// File: rtl/axi_wr_checker.sv
module axi_wr_checker
    import axi_wrchk_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int LEN_W  = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int DONE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_err,
    input  logic                  aw_valid,
    input  logic                  aw_ready,
    input  logic [ID_W-1:0]       aw_id,
    input  logic [LEN_W-1:0]      aw_len,
    input  logic                  w_valid,
    input  logic                  w_ready,
    input  logic [DATA_W-1:0]     w_data,
    input  logic [DATA_W/8-1:0]   w_strb,
    input  logic                  w_last,
    input  logic                  b_valid,
    input  logic                  b_ready,
    input  logic [ID_W-1:0]       b_id,
    input  logic [1:0]            b_resp,
    output logic [NUM_ERR-1:0]    err_flags,
    output logic                  resp_fail,
    output logic [DONE_W-1:0]     done_count
);

    localparam int STRB_W = DATA_W / 8;

    typedef struct packed {
        logic [NUM_ERR-1:0] err;
        logic               fail;
        logic [DONE_W-1:0]  done;
    } top_t;

    top_t q, d;

    logic aw_fire, w_fire, b_fire;
    logic b_match;
    logic v_w, v_aw, v_b;
    logic e_orphan, e_overflow, e_no_addr, e_early, e_missing;
    logic [NUM_ERR-1:0] evt;

    assign aw_fire = aw_valid && aw_ready;
    assign w_fire  = w_valid && w_ready;
    assign b_fire  = b_valid && b_ready;

    axi_wrchk_stall #(.PAY_W(DATA_W + STRB_W + 1)) u_w_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (w_valid),
        .ready   (w_ready),
        .payload ({w_data, w_strb, w_last}),
        .viol    (v_w)
    );

    axi_wrchk_stall #(.PAY_W(ID_W + LEN_W)) u_aw_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (aw_valid),
        .ready   (aw_ready),
        .payload ({aw_id, aw_len}),
        .viol    (v_aw)
    );

    axi_wrchk_stall #(.PAY_W(ID_W + 2)) u_b_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (b_valid),
        .ready   (b_ready),
        .payload ({b_id, b_resp}),
        .viol    (v_b)
    );

    axi_wrchk_queue #(.ID_W(ID_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .aw_fire      (aw_fire),
        .aw_id        (aw_id),
        .aw_len       (aw_len),
        .w_fire       (w_fire),
        .w_last       (w_last),
        .b_fire       (b_fire),
        .b_id         (b_id),
        .b_match      (b_match),
        .err_orphan   (e_orphan),
        .err_overflow (e_overflow),
        .err_no_addr  (e_no_addr),
        .err_early    (e_early),
        .err_missing  (e_missing)
    );

    always_comb begin
        evt                 = '0;
        evt[E_LAST_EARLY]   = e_early;
        evt[E_LAST_MISSING] = e_missing;
        evt[E_W_UNSTABLE]   = v_w;
        evt[E_AW_UNSTABLE]  = v_aw;
        evt[E_B_UNSTABLE]   = v_b;
        evt[E_B_ORPHAN]     = e_orphan;
        evt[E_Q_OVERFLOW]   = e_overflow;
        evt[E_W_NO_ADDR]    = e_no_addr;

        d      = q;
        d.err  = (clr_err ? '0 : q.err) | evt;
        d.fail = (clr_err ? 1'b0 : q.fail) | (b_fire && (b_resp != RESP_OKAY));
        if (b_match) d.done = q.done + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign err_flags  = q.err;
    assign resp_fail  = q.fail;
    assign done_count = q.done;

    // R11
    done_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_match |=> (done_count == $past(done_count) + 1'b1));

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_match |=> $stable(done_count));

    // R12
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_err |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

endmodule

// File: tb/axi_wr_checker_bench.sv
module axi_wr_checker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ID_W   = 4;
    localparam int LEN_W  = 8;
    localparam int DATA_W = 32;
    localparam int DONE_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_err = 1'b0;
    logic aw_valid = 1'b0, aw_ready = 1'b0;
    logic [ID_W-1:0] aw_id = '0;
    logic [LEN_W-1:0] aw_len = '0;
    logic w_valid = 1'b0, w_ready = 1'b0, w_last = 1'b0;
    logic [DATA_W-1:0] w_data = '0;
    logic [DATA_W/8-1:0] w_strb = '0;
    logic b_valid = 1'b0, b_ready = 1'b0;
    logic [ID_W-1:0] b_id = '0;
    logic [1:0] b_resp = '0;
    logic [7:0] err_flags;
    logic resp_fail;
    logic [DONE_W-1:0] done_count;

    int n_chk = 0;
    int n_fail = 0;
    int exp_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axi_wr_checker u_axi_wr_checker (
        .clk(clk), .rst_n(rst_n), .clr_err(clr_err),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
        .err_flags(err_flags), .resp_fail(resp_fail), .done_count(done_count)
    );

    function automatic logic [7:0] ebit(input int idx);
        return 8'(1 << idx);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        aw_valid = 0; aw_ready = 0; w_valid = 0; w_ready = 0; w_last = 0;
        b_valid = 0; b_ready = 0; clr_err = 0;
        cyc(); cyc();
        rst_n = 1'b1;
        exp_done = 0;
    endtask

    task automatic send_aw(input int id, input int len, input int stall);
        aw_valid = 1; aw_ready = 0; aw_id = ID_W'(id); aw_len = LEN_W'(len);
        repeat (stall) cyc();
        aw_ready = 1; cyc();
        aw_valid = 0; aw_ready = 0;
    endtask

    task automatic send_w(input logic [31:0] dat, input logic last, input int stall);
        w_valid = 1; w_ready = 0; w_data = dat; w_strb = dat[3:0]; w_last = last;
        repeat (stall) cyc();
        w_ready = 1; cyc();
        w_valid = 0; w_ready = 0; w_last = 0;
    endtask

    task automatic send_b(input int id, input int resp, input int stall);
        b_valid = 1; b_ready = 0; b_id = ID_W'(id); b_resp = 2'(resp);
        repeat (stall) cyc();
        b_ready = 1; cyc();
        b_valid = 0; b_ready = 0;
    endtask

    task automatic send_burst(input int len);
        for (int k = 0; k <= len; k++) send_w($urandom, k == len, $urandom % 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        int a, b2, la, lb;
        void'($urandom(32'h1357_2468));
        cyc();
        do_reset();
        // R12: reset state
        check("R12 reset err", err_flags, 0);
        check("R12 reset fail", resp_fail, 0);
        check("R11 reset done", done_count, 0);

        // R1 R9 R11 R13: random legal traffic
        for (int t = 0; t < 60; t++) begin
            if (t % 3 == 0) begin
                a = $urandom % 8; b2 = 8 + ($urandom % 8);
                la = $urandom % 6; lb = $urandom % 6;
                send_aw(a, la, $urandom % 3);
                send_aw(b2, lb, $urandom % 3);
                send_burst(la);
                send_burst(lb);
                repeat ($urandom % 10) cyc();
                send_b(b2, 0, $urandom % 3);
                send_b(a, 0, $urandom % 3);
                exp_done += 2;
                check("R13 reordered pair err", err_flags, 0);
            end else begin
                a = $urandom % 16; la = $urandom % 8;
                send_aw(a, la, $urandom % 3);
                send_burst(la);
                repeat ($urandom % 20) cyc();
                send_b(a, 0, $urandom % 3);
                exp_done += 1;
                check("R1 random write err", err_flags, 0);
            end
            check("R11 random done", done_count, exp_done);
        end

        // R1: stalled beat is not counted
        do_reset();
        send_aw(1, 1, 0);
        send_w(32'hA5A5_0001, 0, 3);
        send_w(32'hA5A5_0002, 1, 0);
        send_b(1, 0, 0);
        check("R1 stall not counted", err_flags, 0);

        // R2: early last
        do_reset();
        send_aw(2, 3, 0);
        send_w(32'h1, 0, 0);
        send_w(32'h2, 1, 0);
        check("R2 early last", err_flags, ebit(0));

        // R3: missing last
        do_reset();
        send_aw(2, 1, 0);
        send_w(32'h1, 0, 0);
        send_w(32'h2, 0, 0);
        check("R3 missing last", err_flags, ebit(1));

        // R4: data changed during stall
        do_reset();
        send_aw(0, 0, 0);
        w_valid = 1; w_ready = 0; w_data = 32'hAAAA; w_strb = 4'hF; w_last = 1;
        cyc();
        w_data = 32'hBBBB;
        cyc();
        w_ready = 1; cyc();
        w_valid = 0; w_ready = 0; w_last = 0;
        check("R4 w unstable", err_flags, ebit(2));

        // R5: address changed during stall
        do_reset();
        aw_valid = 1; aw_ready = 0; aw_id = 3; aw_len = 0;
        cyc();
        aw_id = 4;
        cyc();
        aw_ready = 1; cyc();
        aw_valid = 0; aw_ready = 0;
        check("R5 aw unstable", err_flags, ebit(3));

        // R5: response code changed during stall (unknown ID also orphan)
        do_reset();
        b_valid = 1; b_ready = 0; b_id = 0; b_resp = 0;
        cyc();
        b_resp = 1;
        cyc();
        b_resp = 0; b_ready = 1; cyc();
        b_valid = 0; b_ready = 0;
        check("R5 b unstable", err_flags, ebit(4) | ebit(5));

        // R6: duplicate response
        do_reset();
        send_aw(6, 0, 0);
        send_w(32'h6, 1, 0);
        send_b(6, 0, 0);
        check("R6 first response ok", err_flags, 0);
        send_b(6, 0, 0);
        check("R6 duplicate response", err_flags, ebit(5));
        check("R6 done after dup", done_count, 1);

        // R6: response before data finished
        do_reset();
        send_aw(5, 1, 0);
        send_w(32'h5, 0, 0);
        send_b(5, 0, 0);
        check("R6 premature response", err_flags, ebit(5));
        check("R6 premature done", done_count, 0);

        // R7: fifth outstanding address
        do_reset();
        for (int k = 0; k < 4; k++) send_aw(k, 0, 0);
        check("R7 four outstanding", err_flags, 0);
        send_aw(9, 0, 0);
        check("R7 overflow", err_flags, ebit(6));

        // R8: data with no address
        do_reset();
        send_w(32'h8, 1, 0);
        check("R8 no address", err_flags, ebit(7));

        // R9 R11: long response delay, completion only on response
        do_reset();
        send_aw(7, 0, 0);
        send_w(32'h7, 1, 0);
        check("R11 not done on last beat", done_count, 0);
        repeat (600) cyc();
        check("R9 no timeout", err_flags, 0);
        send_b(7, 0, 0);
        check("R11 done on response", done_count, 1);
        check("R9 err after response", err_flags, 0);

        // R10: failure code is status only
        do_reset();
        send_aw(3, 0, 0);
        send_w(32'h3, 1, 0);
        send_b(3, 2, 0);
        check("R10 resp_fail set", resp_fail, 1);
        check("R10 err clear", err_flags, 0);
        check("R10 still completes", done_count, 1);

        // R12: clear, and set in the clear cycle wins
        do_reset();
        send_w(32'h1, 1, 0);
        check("R12 sticky set", err_flags, ebit(7));
        repeat (5) cyc();
        check("R12 sticky held", err_flags, ebit(7));
        clr_err = 1; cyc(); clr_err = 0;
        check("R12 cleared", err_flags, 0);
        clr_err = 1; w_valid = 1; w_ready = 1; w_last = 1; cyc();
        clr_err = 0; w_valid = 0; w_ready = 0; w_last = 0;
        check("R12 set beats clear", err_flags, ebit(7));

        // R13: unknown ID after out-of-order pairing
        do_reset();
        send_aw(1, 0, 0);
        send_aw(2, 0, 0);
        send_w(32'h1, 1, 0);
        send_w(32'h2, 1, 0);
        send_b(2, 0, 0);
        send_b(1, 0, 0);
        check("R13 out of order ok", err_flags, 0);
        check("R13 both done", done_count, 2);
        send_b(3, 0, 0);
        check("R13 unknown id", err_flags, ebit(5));

        report();
        $finish;
    end

endmodule